// File: doc/BRIEF.md
# Isochronous Transfer Buffer Address Generator

This block produces the memory address of each data byte moved during one microframe of an isochronous transfer. A descriptor supplies eight transaction records, one per microframe, and seven page pointers. Each record holds an active flag, a page-select index and a 12-bit byte offset. All bus transactions in one microframe count as a single logical transfer, so a record covers up to three of them and the block keeps no result for each transaction. On a start pulse the block uses the three lowest bits of the frame index to pick a record. It then loads an address made of the chosen page pointer's 20-bit page number and the record's offset.

The data mover pulses an advance strobe with a byte count of 1 to 4. The block adds the count to the in-page offset. When the sum passes the end of a 4 KB page, the block does not carry into the page number. It moves to the next page pointer, keeps the remainder as the new offset and pulses a page-switch flag. If that wrap happens on the last page pointer, the transfer is malformed: the block raises an error, holds the address and ignores further advances until the next start.

Top module: `iso_addr_gen`

## Requirements
- R1: During and after synchronous reset, and before any start, addr_o is 0 and valid_o, err_o and page_sw_o are 0.
- R2: A start pulse selects record number fidx_i[2:0]. Each record is 16 bits wide and record k occupies rec_i[16k+15:16k], laid out as offset [11:0], page select [14:12] and active [15]. Page pointer p occupies page_i[20p+19:20p]. If the record is active and its page select is 0 to 6, then on the next cycle valid_o=1, err_o=0 and addr_o = {page pointer, offset}.
- R3: If the selected record is inactive, then on the next cycle valid_o=0 and err_o=0. addr_o keeps its previous value, and advance strobes have no effect on it until the next start.
- R4: While valid_o=1, an advance of n bytes (n = 1 to 4) that does not reach offset 4096 adds n to addr_o[11:0] on the next cycle and leaves addr_o[31:12] unchanged. With no advance and no start, addr_o holds.
- R5: While valid_o=1, an advance that takes offset + n to 4096 or more moves to page index + 1 on the next cycle. addr_o becomes {next page pointer, (offset + n) - 4096}, and page_sw_o is 1 for exactly that one cycle.
- R6: A wrap while page index 6 is in use sets err_o=1 and valid_o=0 on the next cycle and holds addr_o. Further advances leave addr_o and err_o unchanged until the next start.
- R7: A start that selects an active record whose page select is 7 gives err_o=1 and valid_o=0 on the next cycle and holds addr_o.
- R8: A start clears a previous error, and it takes priority over an advance strobe in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rec_i | input | 128 | Eight packed transaction records |
| page_i | input | 140 | Seven packed 20-bit page pointers |
| fidx_i | input | 14 | Frame index counter; low 3 bits pick the record |
| start_i | input | 1 | Microframe start pulse |
| adv_i | input | 1 | Byte-advance strobe |
| adv_bytes_i | input | 3 | Bytes moved with this strobe, 1 to 4 |
| addr_o | output | 32 | Current buffer address |
| valid_o | output | 1 | Address generation active for this microframe |
| page_sw_o | output | 1 | One-cycle pulse after a move to the next page pointer |
| err_o | output | 1 | Page overrun on the last pointer, or invalid page select |

## Verification
The assertions assume that adv_bytes_i is between 1 and 4 whenever an advance is accepted. Under that assumption two wraps can never happen in back-to-back cycles, so the single-cycle page-switch pulse is checked on that basis. The stimulus only uses byte counts of 1 to 4. It keeps the descriptor inputs constant while a transfer is running and changes the frame index only together with a start pulse. The vectors cover offsets just below the page end, wraps that leave a remainder, a wrap on the last pointer, an inactive record and an out-of-range page select.

// File: rtl/iso_addr_pkg.sv
package iso_addr_pkg;

  localparam int unsigned DEF_NUM_REC = 8;
  localparam int unsigned DEF_NUM_PG  = 7;
  localparam int unsigned DEF_PAGE_W  = 20;
  localparam int unsigned DEF_OFS_W   = 12;
  localparam int unsigned DEF_FIDX_W  = 14;
  localparam int unsigned DEF_MAX_B   = 4;

  typedef enum logic [1:0] {
    STEP_NONE      = 2'd0,
    STEP_IN_PAGE   = 2'd1,
    STEP_NEXT_PAGE = 2'd2,
    STEP_OVERRUN   = 2'd3
  } step_e;

endpackage

// File: rtl/iso_page_mux.sv
module iso_page_mux #(
  parameter int unsigned NUM_PG = 7,
  parameter int unsigned PAGE_W = 20,
  parameter int unsigned IDX_W  = 3
) (
  input  logic [NUM_PG*PAGE_W-1:0] pages_i,
  input  logic [IDX_W-1:0]         idx_i,
  output logic [PAGE_W-1:0]        page_o,
  output logic                     ok_o
);

  logic [PAGE_W-1:0] pg_arr [NUM_PG];

  for (genvar g = 0; g < NUM_PG; g++) begin : g_unpack
    assign pg_arr[g] = pages_i[g*PAGE_W +: PAGE_W];
  end

  always_comb begin
    page_o = '0;
    for (int i = 0; i < NUM_PG; i++) begin
      if (idx_i == IDX_W'(i)) page_o = pg_arr[i];
    end
  end

  assign ok_o = ({1'b0, idx_i} < (IDX_W+1)'(NUM_PG));

endmodule

// File: rtl/iso_rec_select.sv
module iso_rec_select #(
  parameter int unsigned NUM_REC = 8,
  parameter int unsigned OFS_W   = 12,
  parameter int unsigned IDX_W   = 3,
  parameter int unsigned FIDX_W  = 14,
  localparam int unsigned REC_W  = OFS_W + IDX_W + 1,
  localparam int unsigned RSEL_W = $clog2(NUM_REC)
) (
  input  logic [NUM_REC*REC_W-1:0] rec_i,
  input  logic [FIDX_W-1:0]        fidx_i,
  output logic                     act_o,
  output logic [IDX_W-1:0]         psel_o,
  output logic [OFS_W-1:0]         ofs_o
);

  logic [REC_W-1:0]  rec_arr [NUM_REC];
  logic [REC_W-1:0]  rec_sel;
  logic [RSEL_W-1:0] slot;
  logic              unused_fidx;

  for (genvar g = 0; g < NUM_REC; g++) begin : g_unpack
    assign rec_arr[g] = rec_i[g*REC_W +: REC_W];
  end

  assign slot        = fidx_i[RSEL_W-1:0];
  assign unused_fidx = ^fidx_i;

  always_comb begin
    rec_sel = '0;
    for (int i = 0; i < NUM_REC; i++) begin
      if (slot == RSEL_W'(i)) rec_sel = rec_arr[i];
    end
  end

  assign ofs_o  = rec_sel[OFS_W-1:0];
  assign psel_o = rec_sel[OFS_W +: IDX_W];
  assign act_o  = rec_sel[REC_W-1];

endmodule

// File: rtl/iso_ofs_step.sv
module iso_ofs_step
  import iso_addr_pkg::*;
#(
  parameter int unsigned OFS_W  = 12,
  parameter int unsigned IDX_W  = 3,
  parameter int unsigned NUM_PG = 7,
  parameter int unsigned CNT_W  = 3
) (
  input  logic [OFS_W-1:0] ofs_i,
  input  logic [IDX_W-1:0] pidx_i,
  input  logic             adv_i,
  input  logic [CNT_W-1:0] cnt_i,
  output step_e            kind_o,
  output logic [OFS_W-1:0] ofs_nxt_o,
  output logic [IDX_W-1:0] pidx_nxt_o
);

  logic [OFS_W:0] sum;
  logic           carry;
  logic           last_pg;

  assign sum       = {1'b0, ofs_i} + (OFS_W+1)'(cnt_i);
  assign carry     = sum[OFS_W];
  assign last_pg   = (pidx_i == IDX_W'(NUM_PG - 1));
  assign ofs_nxt_o = sum[OFS_W-1:0];

  always_comb begin
    pidx_nxt_o = pidx_i;
    if (!adv_i) begin
      kind_o = STEP_NONE;
    end else if (!carry) begin
      kind_o = STEP_IN_PAGE;
    end else if (last_pg) begin
      kind_o = STEP_OVERRUN;
    end else begin
      kind_o     = STEP_NEXT_PAGE;
      pidx_nxt_o = pidx_i + IDX_W'(1);
    end
  end

endmodule

// File: rtl/iso_addr_gen.sv
module iso_addr_gen
  import iso_addr_pkg::*;
#(
  parameter int unsigned NUM_REC  = DEF_NUM_REC,
  parameter int unsigned NUM_PG   = DEF_NUM_PG,
  parameter int unsigned PAGE_W   = DEF_PAGE_W,
  parameter int unsigned OFS_W    = DEF_OFS_W,
  parameter int unsigned FIDX_W   = DEF_FIDX_W,
  parameter int unsigned MAX_B    = DEF_MAX_B,
  localparam int unsigned IDX_W   = $clog2(NUM_PG),
  localparam int unsigned REC_W   = OFS_W + IDX_W + 1,
  localparam int unsigned CNT_W   = $clog2(MAX_B + 1),
  localparam int unsigned ADDR_W  = PAGE_W + OFS_W
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NUM_REC*REC_W-1:0] rec_i,
  input  logic [NUM_PG*PAGE_W-1:0] page_i,
  input  logic [FIDX_W-1:0]        fidx_i,
  input  logic                     start_i,
  input  logic                     adv_i,
  input  logic [CNT_W-1:0]         adv_bytes_i,
  output logic [ADDR_W-1:0]        addr_o,
  output logic                     valid_o,
  output logic                     page_sw_o,
  output logic                     err_o
);

  logic              rec_act;
  logic [IDX_W-1:0]  rec_psel;
  logic [OFS_W-1:0]  rec_ofs;
  logic [PAGE_W-1:0] start_page;
  logic              start_ok;
  logic [PAGE_W-1:0] next_page;
  logic              next_ok;
  logic              unused_ok;
  logic [IDX_W-1:0]  pidx_q;
  logic [IDX_W-1:0]  pidx_nxt;
  logic [OFS_W-1:0]  ofs_nxt;
  step_e             kind;

  iso_rec_select #(
    .NUM_REC(NUM_REC), .OFS_W(OFS_W), .IDX_W(IDX_W), .FIDX_W(FIDX_W)
  ) u_rec (
    .rec_i (rec_i),
    .fidx_i(fidx_i),
    .act_o (rec_act),
    .psel_o(rec_psel),
    .ofs_o (rec_ofs)
  );

  iso_page_mux #(.NUM_PG(NUM_PG), .PAGE_W(PAGE_W), .IDX_W(IDX_W)) u_pg_start (
    .pages_i(page_i),
    .idx_i  (rec_psel),
    .page_o (start_page),
    .ok_o   (start_ok)
  );

  iso_ofs_step #(
    .OFS_W(OFS_W), .IDX_W(IDX_W), .NUM_PG(NUM_PG), .CNT_W(CNT_W)
  ) u_step (
    .ofs_i     (addr_o[OFS_W-1:0]),
    .pidx_i    (pidx_q),
    .adv_i     (adv_i && valid_o),
    .cnt_i     (adv_bytes_i),
    .kind_o    (kind),
    .ofs_nxt_o (ofs_nxt),
    .pidx_nxt_o(pidx_nxt)
  );

  iso_page_mux #(.NUM_PG(NUM_PG), .PAGE_W(PAGE_W), .IDX_W(IDX_W)) u_pg_next (
    .pages_i(page_i),
    .idx_i  (pidx_nxt),
    .page_o (next_page),
    .ok_o   (next_ok)
  );

  assign unused_ok = next_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_o    <= '0;
      valid_o   <= 1'b0;
      page_sw_o <= 1'b0;
      err_o     <= 1'b0;
      pidx_q    <= '0;
    end else begin
      page_sw_o <= 1'b0;
      if (start_i) begin
        if (rec_act && start_ok) begin
          addr_o  <= {start_page, rec_ofs};
          pidx_q  <= rec_psel;
          valid_o <= 1'b1;
          err_o   <= 1'b0;
        end else begin
          valid_o <= 1'b0;
          err_o   <= rec_act;
        end
      end else begin
        case (kind)
          STEP_IN_PAGE:   addr_o[OFS_W-1:0] <= ofs_nxt;
          STEP_NEXT_PAGE: begin
            addr_o    <= {next_page, ofs_nxt};
            pidx_q    <= pidx_nxt;
            page_sw_o <= 1'b1;
          end
          STEP_OVERRUN: begin
            valid_o <= 1'b0;
            err_o   <= 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  // Input assumption: accepted byte counts stay in 1..MAX_B (R4)
  p_adv_bytes_r4: assert property (@(posedge clk) disable iff (rst)
    (valid_o && adv_i && !start_i) |->
      (adv_bytes_i != '0 && adv_bytes_i <= CNT_W'(MAX_B)));

  p_hold_idle_r4: assert property (@(posedge clk) disable iff (rst)
    (valid_o && !start_i && !adv_i) |=> $stable(addr_o));

  p_idle_r3: assert property (@(posedge clk) disable iff (rst)
    (!valid_o && !err_o && !start_i) |=> (!valid_o && $stable(addr_o)));

  p_sw_pulse_r5: assert property (@(posedge clk) disable iff (rst)
    page_sw_o |=> !page_sw_o);

  p_sw_valid_r5: assert property (@(posedge clk) disable iff (rst)
    page_sw_o |-> valid_o);

  p_err_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (err_o && !start_i) |=> (err_o && $stable(addr_o)));

  p_excl_r6: assert property (@(posedge clk) disable iff (rst)
    !(valid_o && err_o));

endmodule

// File: tb/iso_addr_gen_test.sv
`timescale 1ns/1ps
module iso_addr_gen_test;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [127:0] rec_i;
  logic [139:0] page_i;
  logic [13:0]  fidx_i = '0;
  logic         start_i = 1'b0;
  logic         adv_i = 1'b0;
  logic [2:0]   adv_bytes_i = 3'd1;
  logic [31:0]  addr_o;
  logic         valid_o, page_sw_o, err_o;

  int n_run = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  iso_addr_gen uut (
    .clk(clk), .rst(rst), .rec_i(rec_i), .page_i(page_i), .fidx_i(fidx_i),
    .start_i(start_i), .adv_i(adv_i), .adv_bytes_i(adv_bytes_i),
    .addr_o(addr_o), .valid_o(valid_o), .page_sw_o(page_sw_o), .err_o(err_o)
  );

  typedef struct packed {
    logic [13:0] fr;
    logic [2:0]  nadv;
    logic [2:0]  cnt;
    logic [31:0] addr;
    logic        v;
    logic        e;
    logic        sw;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{14'h0008, 3'd0, 3'd0, 32'h10000100, 1'b1, 1'b0, 1'b0}, // R2
    '{14'h0000, 3'd3, 3'd4, 32'h1000010C, 1'b1, 1'b0, 1'b0}, // R4
    '{14'h0011, 3'd0, 3'd0, 32'h12022FFE, 1'b1, 1'b0, 1'b0}, // R2
    '{14'h0001, 3'd1, 3'd2, 32'h13033000, 1'b1, 1'b0, 1'b1}, // R5
    '{14'h0015, 3'd1, 3'd4, 32'h16066001, 1'b1, 1'b0, 1'b1}, // R5
    '{14'h0003, 3'd0, 3'd0, 32'h16066FFC, 1'b1, 1'b0, 1'b0}, // R2
    '{14'h0003, 3'd1, 3'd4, 32'h16066FFC, 1'b0, 1'b1, 1'b0}, // R6
    '{14'h0003, 3'd2, 3'd4, 32'h16066FFC, 1'b0, 1'b1, 1'b0}, // R6
    '{14'h0002, 3'd2, 3'd1, 32'h16066FFC, 1'b0, 1'b0, 1'b0}, // R3
    '{14'h0004, 3'd0, 3'd0, 32'h16066FFC, 1'b0, 1'b1, 1'b0}, // R7
    '{14'h0006, 3'd4, 3'd3, 32'h1303300C, 1'b1, 1'b0, 1'b0}, // R4
    '{14'h0007, 3'd2, 3'd4, 32'h110117F8, 1'b1, 1'b0, 1'b0}  // R4
  };
  localparam string VTAG [NV] = '{"R2", "R4", "R2", "R5", "R5", "R2",
                                  "R6", "R6", "R3", "R7", "R4", "R4"};

  task automatic chk(input string tag, input logic [31:0] ea,
                     input logic ev, input logic ee, input logic es);
    n_run++;
    if (addr_o !== ea || valid_o !== ev || err_o !== ee || page_sw_o !== es) begin
      n_fail++;
      $display("FAIL %s: addr=%h valid=%b err=%b sw=%b expected addr=%h valid=%b err=%b sw=%b",
               tag, addr_o, valid_o, err_o, page_sw_o, ea, ev, ee, es);
    end
  endtask

  task automatic do_start(input logic [13:0] fr);
    @(negedge clk);
    fidx_i  = fr;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic do_adv(input int n, input logic [2:0] c);
    for (int k = 0; k < n; k++) begin
      adv_i       = 1'b1;
      adv_bytes_i = c;
      @(negedge clk);
    end
    adv_i = 1'b0;
  endtask

  initial begin
    #(20 * 150000);
    n_fail++;
    $display("FAIL watchdog: run did not finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rec_i = {16'h97F0, 16'hB000, 16'hDFFD, 16'hF000,
             16'hEFFC, 16'h1010, 16'hAFFE, 16'h8100};
    for (int i = 0; i < 7; i++) page_i[i*20 +: 20] = 20'h10000 + 20'(i) * 20'h01011;

    repeat (3) @(negedge clk);
    chk("R1 in reset", 32'h0, 1'b0, 1'b0, 1'b0);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1 after reset", 32'h0, 1'b0, 1'b0, 1'b0);

    for (int v = 0; v < NV; v++) begin
      do_start(VECS[v].fr);
      do_adv(int'(VECS[v].nadv), VECS[v].cnt);
      chk(VTAG[v], VECS[v].addr, VECS[v].v, VECS[v].e, VECS[v].sw);
    end

    // R8: start wins over a simultaneous advance
    @(negedge clk);
    fidx_i = 14'h0000; start_i = 1'b1; adv_i = 1'b1; adv_bytes_i = 3'd4;
    @(negedge clk);
    start_i = 1'b0; adv_i = 1'b0;
    chk("R8 start priority", 32'h10000100, 1'b1, 1'b0, 1'b0);

    // R5: page-switch pulse lasts one cycle
    do_start(14'h0001);
    do_adv(1, 3'd2);
    chk("R5 pulse high", 32'h13033000, 1'b1, 1'b0, 1'b1);
    @(negedge clk);
    chk("R5 pulse low", 32'h13033000, 1'b1, 1'b0, 1'b0);

    // R4: address holds with no strobe
    repeat (3) @(negedge clk);
    chk("R4 idle hold", 32'h13033000, 1'b1, 1'b0, 1'b0);

    // R8: new start clears an overrun error
    do_start(14'h0003);
    do_adv(1, 3'd4);
    chk("R6 overrun", 32'h16066FFC, 1'b0, 1'b1, 1'b0);
    do_start(14'h0000);
    chk("R8 error cleared", 32'h10000100, 1'b1, 1'b0, 1'b0);

    // R3: advances after an inactive start leave the address alone
    do_start(14'h000A);
    do_adv(3, 3'd4);
    chk("R3 inactive ignores advance", 32'h10000100, 1'b0, 1'b0, 1'b0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule